// File: doc/BRIEF.md
# I2C Pin Recovery Multiplexer

This block sits between an I2C engine's open-drain pull-down controls and the SCL/SDA pads. In normal operation it is transparent: the engine's pull-down requests go straight to the pads. When a bus is stuck, software can take both pins away from the engine with a single function bit. Each pin can then be driven from an output latch, under control of a per-pin direction bit, and clock pulses can be toggled out by hand. Software does the clocking itself; the block only supplies the pin control.

The output latch has no plain write path. Software changes it through two strobe vectors: one sets bits and the other clears them. A zero in a strobe leaves the bit alone, so one pin can be changed without reading the other first. Both pads are always sampled through a synchronizer, whichever mode is active, so software can see the level on each line.

All two-bit pin vectors use the same bit order: bit 0 is SCL and bit 1 is SDA. The pins are open-drain. A high output, or a pin configured as an input, releases the line; it never drives it high.

Top module: `i2c_pin_recovery_mux`

## Requirements
- R1: After reset the function bit and both direction bits are 0, the output latch is 2'b11, and `pin_level` reads 2'b11.
- R2: While the function bit is 0, `pad_pull_low` equals `eng_pull_low` in the same cycle, whatever the direction bits and the latch hold.
- R3: A cycle with `wr_en`=1 and `wr_sel`=0 loads the function bit from `wr_data[0]`. With `wr_sel`=1 it loads the direction bits from `wr_data[1:0]`, where 1 means output. The new value takes effect after that clock edge.
- R4: While the function bit is 1, a pin whose direction bit is 0 is released (`pad_pull_low` bit is 0), regardless of the latch and of `eng_pull_low`.
- R5: While the function bit is 1, a pin whose direction bit is 1 is pulled low exactly when its latch bit is 0.
- R6: A 1 in `set_bits[i]` sets latch bit i at the next edge.
- R7: A 0 in both `set_bits[i]` and `clr_bits[i]` leaves latch bit i unchanged.
- R8: A 1 in `clr_bits[i]` clears latch bit i at the next edge, even when `set_bits[i]` is also 1 in the same cycle.
- R9: `pin_level` shows `pad_in` delayed by exactly two clock edges, in both modes.
- R10: Latch and direction updates made while the function bit is 0 are kept, and they take effect as soon as the function bit becomes 1.
- R11: Clearing the function bit returns both pins to engine pass-through from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | 0 selects the function bit, 1 selects the direction bits |
| wr_data | input | 2 | Configuration write data |
| set_bits | input | 2 | Write-one-to-set strobes for the output latch |
| clr_bits | input | 2 | Write-one-to-clear strobes for the output latch (these win over set) |
| eng_pull_low | input | 2 | Engine pull-down requests (bit 0 SCL, bit 1 SDA) |
| pad_in | input | 2 | Pad levels (bit 0 SCL, bit 1 SDA) |
| pad_pull_low | output | 2 | Open-drain pull-down to the pads |
| pin_level | output | 2 | Synchronized pad levels |

## Verification
The bench builds the block with the default two-stage synchronizer and a latch reset of 2'b11. This makes the two-edge input delay and the released-bus reset state exact values to check against. A behavioural model built from flags and a queue follows every write, strobe and pad change. Directed steps cover set and clear colliding on the same bit, latch updates made while the block is in engine mode, and switching back and forth between modes. After that, random strobes and mode changes exercise every combination of direction and latch values in both modes.

// File: rtl/i2c_pin_recovery_mux.sv
module i2c_pin_recovery_mux #(
  parameter int SYNC_STAGES = 2,
  parameter logic [1:0] LATCH_INIT = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [1:0] wr_data,
  input  logic [1:0] set_bits,
  input  logic [1:0] clr_bits,
  input  logic [1:0] eng_pull_low,
  input  logic [1:0] pad_in,
  output logic [1:0] pad_pull_low,
  output logic [1:0] pin_level
);
  localparam int LAST = SYNC_STAGES - 1;

  logic       gpio_mode;
  logic [1:0] dir_out;
  logic [1:0] out_latch;
  logic [1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_mode <= 1'b0;
      dir_out   <= 2'b00;
    end else if (wr_en) begin
      if (wr_sel) dir_out   <= wr_data;
      else        gpio_mode <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_latch <= LATCH_INIT;
    else        out_latch <= (out_latch | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= 2'b11;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_level    = sync_q[LAST];
  assign pad_pull_low = gpio_mode ? (dir_out & ~out_latch) : eng_pull_low;

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_latch & ($past(set_bits) & ~$past(clr_bits))) == ($past(set_bits) & ~$past(clr_bits))))
    else $error("latch bit not set");

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_latch & $past(clr_bits)) == 2'b00))
    else $error("latch bit not cleared");

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == 2'b00 && clr_bits == 2'b00) |=> $stable(out_latch))
    else $error("latch changed without strobe");

  assert_func_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (gpio_mode == $past(wr_data[0])))
    else $error("function bit not loaded");

  assert_released_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_mode |-> ((pad_pull_low & ~dir_out) == 2'b00))
    else $error("input pin pulled low");
endmodule

// File: tb/i2c_pin_recovery_mux_test.sv
module i2c_pin_recovery_mux_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [1:0] wr_data = 2'b00, set_bits = 2'b00, clr_bits = 2'b00;
  logic [1:0] eng_pull_low = 2'b00, pad_in = 2'b11;
  logic [1:0] pad_pull_low, pin_level;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_pin_recovery_mux uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .set_bits(set_bits), .clr_bits(clr_bits), .eng_pull_low(eng_pull_low),
    .pad_in(pad_in), .pad_pull_low(pad_pull_low), .pin_level(pin_level));

  // behavioural reference
  bit m_gpio;
  bit [1:0] m_dir, m_lat, m_lvl;
  bit [1:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gpio = 0; m_dir = 0; m_lat = 2'b11; m_lvl = 2'b11;
      m_q = {};
      m_q.push_back(2'b11);
    end else begin
      if (wr_en && !wr_sel) m_gpio = wr_data[0];
      if (wr_en && wr_sel) m_dir = wr_data;
      for (int i = 0; i < 2; i++) begin
        if (clr_bits[i]) m_lat[i] = 1'b0;
        else if (set_bits[i]) m_lat[i] = 1'b1;
      end
      m_q.push_back(pad_in);
      m_lvl = m_q.pop_front();
    end
  end

  function automatic bit [1:0] m_pull();
    bit [1:0] r;
    for (int i = 0; i < 2; i++)
      r[i] = m_gpio ? (m_dir[i] ? !m_lat[i] : 1'b0) : eng_pull_low[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(m_gpio ? "R5 (pull, GPIO mode)" : "R2 (pull, engine mode)", pad_pull_low, m_pull());
      check("R9 (pin level)", pin_level, m_lvl);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; set_bits = 0; clr_bits = 0;
  endtask

  task automatic cfg(input bit sel, input logic [1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pull after reset", pad_pull_low, 2'b00);
    check("R1 level after reset", pin_level, 2'b11);
    eng_pull_low = 2'b11; #1;
    check("R2 engine passthrough", pad_pull_low, 2'b11);
    eng_pull_low = 2'b10; #1;
    check("R2 engine passthrough", pad_pull_low, 2'b10);
    // R10: latch and direction changed in engine mode are retained
    clr_bits = 2'b01; step();
    cfg(1'b1, 2'b11);
    check("R10 engine mode unaffected", pad_pull_low, 2'b10);
    cfg(1'b0, 2'b01);
    check("R3 R10 gpio entry uses stored latch", pad_pull_low, 2'b01);
    set_bits = 2'b01; step();
    check("R6 set releases SCL", pad_pull_low, 2'b00);
    set_bits = 2'b11; clr_bits = 2'b11; step();
    check("R8 clear wins", pad_pull_low, 2'b11);
    step();
    check("R7 no strobe keeps latch", pad_pull_low, 2'b11);
    cfg(1'b1, 2'b01);
    check("R4 SDA input released", pad_pull_low, 2'b01);
    eng_pull_low = 2'b11; #1;
    check("R4 engine ignored in gpio", pad_pull_low, 2'b01);
    cfg(1'b0, 2'b00);
    check("R11 back to engine", pad_pull_low, 2'b11);
    // R9 two-edge sync
    pad_in = 2'b10; step();
    check("R9 one edge: old level", pin_level, 2'b11);
    step();
    check("R9 two edges: new level", pin_level, 2'b10);
    // random phase
    for (int n = 0; n < 600; n++) begin
      wr_en = ($urandom % 4) == 0;
      wr_sel = $urandom;
      wr_data = $urandom;
      set_bits = $urandom;
      clr_bits = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      eng_pull_low = $urandom;
      pad_in = $urandom;
      @(posedge clk);
      @(negedge clk);
    end
    finish_run();
  end
endmodule